// File: doc/BRIEF.md
# Offset / Normalized Min-Sum Check Node

This block is the check-node half of an approximate belief-propagation decoder for low-density parity-check codes. Each parity check connects to a fixed number of edges. Their variable-to-check messages arrive one per cycle as 6-bit two's-complement fixed-point values with two fractional bits, so the range is -8.00 to +7.75. While the messages stream in, the block keeps a short summary: the smallest and second-smallest magnitude, the arrival position of the smallest, the parity of all sign bits, and each edge's own sign bit. The block uses no log-tanh tables and no adders in the magnitude path. Comparisons alone produce the magnitude result.

After the last edge of a check is accepted, the block sends one check-to-variable message per edge, in arrival order. Each message carries the smallest magnitude among the other edges, after a static correction. The correction either subtracts an offset and floors the result at zero, or multiplies by a fixed-point factor and truncates. The sign of each message is the product of the other edges' signs. The summary is double-buffered, so the next check streams in while the previous one streams out, at one message per cycle in each direction.

Top module: `mns_check_node`

## Requirements
- R1: With offset correction and an offset of 0, the magnitude sent to edge i is the smallest magnitude over all edges other than i.
- R2: The output sign for edge i is the XOR of the sign bits of every other edge. A zero magnitude is always sent as the value 0.
- R3: With `corr_mode` = 0 (offset), the magnitude becomes the excluding-self minimum minus `beta`, floored at zero. An offset of 1 (one LSB, 0.25) is supported, and any `beta` of 32 or more forces every output to 0.
- R4: With `corr_mode` = 1 (scale), the magnitude becomes floor(min × `alpha` / 16). `alpha` is unsigned with 4 fractional bits, so 16 means 1.0 and 0 forces all outputs to 0.
- R5: Messages are 6-bit two's complement with 2 fractional bits. An input of -8.00 (raw 100000) counts as magnitude 32. A positive result above 31 saturates to 31 (+7.75). A negative result keeps magnitude 32 as -8.00.
- R6: When two or more edges share the smallest magnitude, every edge receives that same magnitude before correction.
- R7: The outputs for a check start in the cycle right after the edge that accepts its last input. `out_valid` stays high for exactly DEG cycles, and `out_idx` counts 0 to DEG-1, where index k is the k-th accepted input.
- R8: The next check's inputs can be accepted back-to-back while the previous check is being output, with no lost or stalled message.
- R9: A cycle with `in_valid` low is ignored. Only accepted inputs advance the edge count, and no output appears before a check is complete.
- R10: Synchronous active-low reset clears `out_valid` and discards any partly received check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| corr_mode | input | 1 | Correction select, static: 0 = offset, 1 = scale |
| beta | input | 6 | Offset in LSB units (0.25), static |
| alpha | input | 5 | Scale factor, unsigned with 4 fractional bits, static |
| in_valid | input | 1 | Input message strobe |
| in_msg | input | 6 | Variable-to-check message, two's complement with 2 fractional bits |
| out_valid | output | 1 | Output message strobe |
| out_idx | output | 3 | Edge position of the current output |
| out_msg | output | 6 | Check-to-variable message, same format as the input |

## Verification
The hardest case to reach from the ports is the hand-over between checks. The last input of one check, the load of the output buffer, and the first output and first input of the next check all fall on neighbouring edges. This is where a summary could be overwritten or an edge count could slip. The stimulus streams several checks with no gap and compares each output against an excluding-self minimum computed by brute force. It then repeats the run with gaps on the input strobe and with a reset part-way through a check. The vectors include all-equal magnitudes, all -8.00 and all +7.75, so ties and saturation land on every edge position.

// File: rtl/mns_pkg.sv
// Shared definitions for the min-sum check node.
// Assumes: the correction mode is a single static select bit.
package mns_pkg;
    typedef enum logic {
        CORR_OFFSET = 1'b0,
        CORR_SCALE  = 1'b1
    } corr_mode_e;
endpackage

// File: rtl/mns_collect.sv
// Running summary of one check: two smallest magnitudes, position of the
// smallest, sign parity and per-edge sign bits. The next-state summary is
// exported combinationally together with a strobe marking the last edge.
// Assumes: DEG >= 2; inputs are two's complement MSG_W bits.
module mns_collect #(
    parameter int DEG   = 8,
    parameter int MSG_W = 6,
    parameter int IDX_W = (DEG > 1) ? $clog2(DEG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [MSG_W-1:0] in_msg,
    output logic             done,
    output logic [MSG_W-1:0] nx_min1,
    output logic [MSG_W-1:0] nx_min2,
    output logic [IDX_W-1:0] nx_idx,
    output logic             nx_par,
    output logic [DEG-1:0]   nx_signs
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEG - 1);

    logic [IDX_W-1:0] cnt;
    logic [MSG_W-1:0] min1_q, min2_q;
    logic [IDX_W-1:0] idx_q;
    logic             par_q;
    logic [DEG-1:0]   signs_q;
    logic             sgn, first;
    logic [MSG_W-1:0] mag, b_min1, b_min2;

    // Magnitude and sign of the incoming message (-32 maps to 32 unsigned).
    always_comb begin
        sgn   = in_msg[MSG_W-1];
        mag   = sgn ? (~in_msg + MSG_W'(1)) : in_msg;
        first = (cnt == '0);
        done  = in_valid && (cnt == LAST);
    end

    // Compare-and-insert into the two-smallest list; strict compare keeps ties in min2.
    always_comb begin
        b_min1   = first ? '1 : min1_q;
        b_min2   = first ? '1 : min2_q;
        nx_idx   = first ? '0 : idx_q;
        nx_par   = (first ? 1'b0 : par_q) ^ sgn;
        nx_signs = first ? '0 : signs_q;
        for (int k = 0; k < DEG; k++) begin
            if (cnt == IDX_W'(k)) nx_signs[k] = sgn;
        end
        nx_min1 = b_min1;
        nx_min2 = b_min2;
        if (mag < b_min1) begin
            nx_min1 = mag;
            nx_min2 = b_min1;
            nx_idx  = cnt;
        end else if (mag < b_min2) begin
            nx_min2 = mag;
        end
    end

    // Edge counter and summary registers advance only on accepted inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            min1_q  <= '1;
            min2_q  <= '1;
            idx_q   <= '0;
            par_q   <= 1'b0;
            signs_q <= '0;
        end else if (in_valid) begin
            cnt     <= done ? '0 : cnt + IDX_W'(1);
            min1_q  <= nx_min1;
            min2_q  <= nx_min2;
            idx_q   <= nx_idx;
            par_q   <= nx_par;
            signs_q <= nx_signs;
        end
    end
endmodule

// File: rtl/mns_correct.sv
// Magnitude correction: offset with zero floor, or fixed-point scaling with
// truncation. Purely combinational.
// Assumes: ALPHA_W > ALPHA_FRAC so the result is at least one bit wider than MAG_W.
module mns_correct #(
    parameter int MAG_W      = 6,
    parameter int ALPHA_W    = 5,
    parameter int ALPHA_FRAC = 4,
    parameter int RES_W      = MAG_W + ALPHA_W - ALPHA_FRAC
) (
    input  logic               scale_sel,
    input  logic [MAG_W-1:0]   mag,
    input  logic [MAG_W-1:0]   beta,
    input  logic [ALPHA_W-1:0] alpha,
    output logic [RES_W-1:0]   res
);
    localparam int PROD_W = MAG_W + ALPHA_W;

    logic [PROD_W-1:0] prod;

    // Select offset-and-floor or multiply-and-truncate.
    always_comb begin
        prod = {{ALPHA_W{1'b0}}, mag} * {{MAG_W{1'b0}}, alpha};
        if (scale_sel)
            res = RES_W'(prod >> ALPHA_FRAC);
        else if (mag > beta)
            res = RES_W'(mag - beta);
        else
            res = '0;
    end
endmodule

// File: rtl/mns_pack.sv
// Turns sign plus corrected magnitude into a saturated two's complement message.
// Assumes: RES_W > MSG_W - 1.
module mns_pack #(
    parameter int MSG_W = 6,
    parameter int RES_W = 7
) (
    input  logic             neg,
    input  logic [RES_W-1:0] mag,
    output logic [MSG_W-1:0] msg
);
    localparam logic [RES_W-1:0] POS_LIM = RES_W'((1 << (MSG_W - 1)) - 1);
    localparam logic [RES_W-1:0] NEG_LIM = RES_W'(1 << (MSG_W - 1));

    logic [RES_W-1:0] m;

    // Clip to the asymmetric range and apply the sign.
    always_comb begin
        if (neg) begin
            m   = (mag > NEG_LIM) ? NEG_LIM : mag;
            msg = MSG_W'(0) - m[MSG_W-1:0];
        end else begin
            m   = (mag > POS_LIM) ? POS_LIM : mag;
            msg = m[MSG_W-1:0];
        end
    end
endmodule

// File: rtl/mns_check_node.sv
// Min-sum check node. Collects DEG messages per check, then outputs DEG
// corrected excluding-self messages, one per cycle, while the next check is
// collected. Output message is combinational from the output buffer.
// Assumes: corr_mode, beta and alpha are static while a check is in flight.
module mns_check_node #(
    parameter int DEG        = 8,
    parameter int MSG_W      = 6,
    parameter int ALPHA_W    = 5,
    parameter int ALPHA_FRAC = 4,
    parameter int IDX_W      = (DEG > 1) ? $clog2(DEG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               corr_mode,
    input  logic [MSG_W-1:0]   beta,
    input  logic [ALPHA_W-1:0] alpha,
    input  logic               in_valid,
    input  logic [MSG_W-1:0]   in_msg,
    output logic               out_valid,
    output logic [IDX_W-1:0]   out_idx,
    output logic [MSG_W-1:0]   out_msg
);
    import mns_pkg::*;

    localparam int               RES_W = MSG_W + ALPHA_W - ALPHA_FRAC;
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEG - 1);

    logic             done;
    logic [MSG_W-1:0] nx_min1, nx_min2;
    logic [IDX_W-1:0] nx_idx;
    logic             nx_par;
    logic [DEG-1:0]   nx_signs;

    logic [MSG_W-1:0] b_min1, b_min2;
    logic [IDX_W-1:0] b_idx;
    logic             b_par;
    logic [DEG-1:0]   b_signs;
    logic             busy;
    logic [IDX_W-1:0] ocnt;

    logic [MSG_W-1:0] sel_mag;
    logic             own_sgn, out_neg;
    logic [RES_W-1:0] corr_mag;

    mns_collect #(.DEG(DEG), .MSG_W(MSG_W), .IDX_W(IDX_W)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_msg   (in_msg),
        .done     (done),
        .nx_min1  (nx_min1),
        .nx_min2  (nx_min2),
        .nx_idx   (nx_idx),
        .nx_par   (nx_par),
        .nx_signs (nx_signs)
    );

    // Output buffer: captures the finished summary as the last edge is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_min1  <= '0;
            b_min2  <= '0;
            b_idx   <= '0;
            b_par   <= 1'b0;
            b_signs <= '0;
        end else if (done) begin
            b_min1  <= nx_min1;
            b_min2  <= nx_min2;
            b_idx   <= nx_idx;
            b_par   <= nx_par;
            b_signs <= nx_signs;
        end
    end

    // Output sequencer: DEG cycles per check, restarted by a new load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ocnt <= '0;
        end else if (done) begin
            busy <= 1'b1;
            ocnt <= '0;
        end else if (busy) begin
            busy <= (ocnt != LAST);
            ocnt <= (ocnt == LAST) ? '0 : ocnt + IDX_W'(1);
        end
    end

    // Excluding-self magnitude and sign for the edge being output.
    always_comb begin
        sel_mag = (ocnt == b_idx) ? b_min2 : b_min1;
        own_sgn = 1'b0;
        for (int k = 0; k < DEG; k++) begin
            if (ocnt == IDX_W'(k)) own_sgn = b_signs[k];
        end
        out_neg = b_par ^ own_sgn;
    end

    mns_correct #(.MAG_W(MSG_W), .ALPHA_W(ALPHA_W), .ALPHA_FRAC(ALPHA_FRAC), .RES_W(RES_W)) u_correct (
        .scale_sel (corr_mode == CORR_SCALE),
        .mag       (sel_mag),
        .beta      (beta),
        .alpha     (alpha),
        .res       (corr_mag)
    );

    mns_pack #(.MSG_W(MSG_W), .RES_W(RES_W)) u_pack (
        .neg (out_neg),
        .mag (corr_mag),
        .msg (out_msg)
    );

    assign out_valid = busy;
    assign out_idx   = ocnt;
endmodule

// File: rtl/mns_check_node_sva.sv
// Property checker for the min-sum check node, bound to every instance.
// Assumes: static correction inputs, synchronous active-low reset.
module mns_check_node_sva #(
    parameter int DEG     = 8,
    parameter int MSG_W   = 6,
    parameter int ALPHA_W = 5,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               corr_mode,
    input logic [MSG_W-1:0]   beta,
    input logic [ALPHA_W-1:0] alpha,
    input logic               in_valid,
    input logic               out_valid,
    input logic [IDX_W-1:0]   out_idx,
    input logic [MSG_W-1:0]   out_msg
);
    import mns_pkg::*;

    localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEG - 1);
    localparam logic [IDX_W:0]   DEG_V   = (IDX_W + 1)'(DEG);
    localparam logic [MSG_W-1:0] MAX_MAG = MSG_W'(1 << (MSG_W - 1));

    logic [IDX_W:0] acc;

    // Count accepted inputs since reset, saturating at one full check.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else if (in_valid && acc < DEG_V) acc <= acc + 1'b1;
    end

    p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx != LAST) |=> (out_valid && out_idx == $past(out_idx) + IDX_W'(1)));

    p_idx_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == '0));

    p_needs_full_check_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (acc >= DEG_V));

    p_big_offset_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && corr_mode == CORR_OFFSET && beta >= MAX_MAG) |-> (out_msg == '0));

    p_zero_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && corr_mode == CORR_SCALE && alpha == '0) |-> (out_msg == '0));
endmodule

bind mns_check_node mns_check_node_sva #(
    .DEG(DEG), .MSG_W(MSG_W), .ALPHA_W(ALPHA_W), .IDX_W(IDX_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .corr_mode (corr_mode),
    .beta      (beta),
    .alpha     (alpha),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_msg   (out_msg)
);

// File: tb/tb_mns_check_node.sv
`timescale 1ns/1ps
module tb_mns_check_node;
    import mns_pkg::*;

    localparam int DEG = 8, MSG_W = 6, ALPHA_W = 5, ALPHA_FRAC = 4, IDX_W = 3, NV = 7;

    // Stimulus table: one check per entry, edge k at bits [6k+5:6k].
    localparam logic [DEG*MSG_W-1:0] VEC [NV] = '{
        48'h820820820820,   // all -8.00
        48'h7DF7DF7DF7DF,   // all +7.75
        48'h000000000000,   // all zero
        48'h123456789ABC,
        48'hFEDCBA987654,
        48'h0F1E2D3C4B5A,
        48'h8207DF000FC1
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               corr_mode;
    logic [MSG_W-1:0]   beta;
    logic [ALPHA_W-1:0] alpha;
    logic               in_valid;
    logic [MSG_W-1:0]   in_msg;
    logic               out_valid;
    logic [IDX_W-1:0]   out_idx;
    logic [MSG_W-1:0]   out_msg;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mns_check_node dut (
        .clk(clk), .rst_n(rst_n), .corr_mode(corr_mode), .beta(beta), .alpha(alpha),
        .in_valid(in_valid), .in_msg(in_msg),
        .out_valid(out_valid), .out_idx(out_idx), .out_msg(out_msg)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MSG_W-1:0] get_msg(logic [DEG*MSG_W-1:0] v, int i);
        return v[i*MSG_W +: MSG_W];
    endfunction

    function automatic string vtag(int c);
        case (c)
            0: return "R5 R6";
            1: return "R5 R6";
            2: return "R6";
            default: return "";
        endcase
    endfunction

    // Reference: brute-force excluding-self minimum, sign product, correction, clip.
    function automatic logic [MSG_W-1:0] ref_out(logic [DEG*MSG_W-1:0] v, int i);
        int m = 1000;
        bit s = 0;
        int r;
        for (int j = 0; j < DEG; j++) begin
            if (j != i) begin
                int x = $signed(get_msg(v, j));
                int a = (x < 0) ? -x : x;
                if (a < m) m = a;
                s ^= (x < 0);
            end
        end
        if (corr_mode == CORR_OFFSET) m = (m > int'(beta)) ? m - int'(beta) : 0;
        else m = (m * int'(alpha)) >> ALPHA_FRAC;
        if (s) r = -((m > 32) ? 32 : m);
        else   r = (m > 31) ? 31 : m;
        return MSG_W'(r);
    endfunction

    // Back-to-back stream of all table entries, outputs checked during next inputs (R8).
    task automatic run_stream(string seg);
        for (int c = 0; c <= NV; c++) begin
            for (int i = 0; i < DEG; i++) begin
                @(negedge clk);
                if (c > 0) begin
                    string t;
                    t = {seg, " ", vtag(c - 1)};
                    chk({t, " R7 R8 valid"}, 32'(out_valid), 32'd1);
                    chk({t, " R7 idx"}, 32'(out_idx), 32'(i));
                    chk({t, " msg"}, 32'(out_msg), 32'(ref_out(VEC[c-1], i)));
                end
                if (c < NV) begin
                    in_valid = 1'b1;
                    in_msg   = get_msg(VEC[c], i);
                end else begin
                    in_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        chk({seg, " R7 drain"}, 32'(out_valid), 32'd0);
    endtask

    task automatic read_check(string tag, logic [DEG*MSG_W-1:0] v);
        for (int k = 0; k < DEG; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk({tag, " valid"}, 32'(out_valid), 32'd1);
            chk({tag, " msg"}, 32'(out_msg), 32'(ref_out(v, k)));
        end
        @(negedge clk);
        chk({tag, " end"}, 32'(out_valid), 32'd0);
    endtask

    task automatic final_report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog expired");
        final_report();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_msg = '0;
        corr_mode = CORR_OFFSET; beta = '0; alpha = 5'd16;
        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        corr_mode = CORR_OFFSET; beta = 6'd0;  run_stream("R1 R2 off0");
        corr_mode = CORR_OFFSET; beta = 6'd1;  run_stream("R3 off1");
        corr_mode = CORR_OFFSET; beta = 6'd6;  run_stream("R3 off6");
        corr_mode = CORR_OFFSET; beta = 6'd40; run_stream("R3 off40");
        corr_mode = CORR_SCALE;  alpha = 5'd12; run_stream("R4 a0.75");
        corr_mode = CORR_SCALE;  alpha = 5'd16; run_stream("R4 a1.0");
        corr_mode = CORR_SCALE;  alpha = 5'd0;  run_stream("R4 a0");

        // R9: idle cycles between inputs are ignored.
        corr_mode = CORR_OFFSET; beta = 6'd1;
        for (int i = 0; i < DEG; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_msg   = get_msg(VEC[4], i);
            if (i < DEG - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                chk("R9 no early output", 32'(out_valid), 32'd0);
            end
        end
        read_check("R9 gapped", VEC[4]);

        // R10: reset mid-check discards the partial check.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_msg   = get_msg(VEC[5], i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 after reset", 32'(out_valid), 32'd0);
        for (int i = 0; i < DEG; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_msg   = get_msg(VEC[3], i);
        end
        read_check("R10 after partial", VEC[3]);

        final_report();
    end
endmodule